// File: doc/BRIEF.md
# Tagged Memory Fill Engine

This block fills a region of memory with one repeated byte value. For every 16-byte granule it fills, it also stores a 4-bit allocation tag. Software drives it through three commands issued one after the other. The prologue checks the operands and converts them into the working form for the chosen counting convention. The main stage writes every whole block that remains. The epilogue writes whatever is left.

The block supports two conventions. In the first, the address is moved to the end of the region and the size becomes negative, counting up to zero. In the second, the address and size both count down directly. Each command returns the updated address and size, which software feeds into the next command. It also returns a 4-bit flags value that identifies the convention in use.

Memory writes leave on a block-wide port, and each is answered with the number of bytes actually written. Tag stores leave one granule at a time on a separate port, which answers with an ack or an error. A short write, a tag error or a misaligned operand ends the command with a fault and a fault address.

Top module: `tag_fill_engine`

## Requirements
- R1: Every byte written equals bit 7..0 of `data_i`, and only bytes inside the requested region change.
- R2: Prologue (stage code 0) takes the size as unsigned and clamps it to `MAX_SIZE`. It faults when the clamped size has nonzero bits 3..0, or when the size is nonzero and address bits 3..0 are nonzero. On a fault it reports `fault_addr_o` = address and returns the address, size and flags unchanged.
- R3: A prologue that does not fault with `opt_b_i`=0 sets flags to 4'b0000, returns address + size, and returns the two's-complement negation of the size.
- R4: A prologue that does not fault with `opt_b_i`=1 sets flags to 4'b0010 and returns the address and the clamped size unchanged.
- R5: With `opt_b_i`=0, main and epilogue take the size as signed and write at address + size. After each block, the size rises by the block length and the address stays fixed.
- R6: With `opt_b_i`=1, main and epilogue write at the address. After each block, the address rises by the block length and the size falls by the same amount.
- R7: Main (stage code 1) writes every whole `BLK_BYTES` block of the remaining count. Epilogue (stage code 2) writes all of the remaining count. Each write is 16-byte aligned and its length is a nonzero multiple of 16 that is no more than `BLK_BYTES`.
- R8: Main or epilogue faults without writing when size bits 3..0 are nonzero, or when the size is nonzero and address bits 3..0 are nonzero. `fault_addr_o` is address + size when `opt_b_i`=0 and the address when `opt_b_i`=1.
- R9: Each granule gets one tag store, whose value is bits 59..56 of the block's start address. Within a block, tags are stored from the last granule down to the first.
- R10: If `mem_cnt_i` is below the requested length, the command stops with a fault. `fault_addr_o` is that block's address, and address and size reflect only the blocks that completed.
- R11: A tag error stops the command with a fault. Address and size exclude the block being tagged.
- R12: Flags change only at the end of a prologue. Main and epilogue return `flags_i`.
- R13: `start_i` is accepted only when idle, and stage code 3 is ignored. `done_o` is high for exactly one cycle per command, while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command |
| stage_i | input | 2 | 0 prologue, 1 main, 2 epilogue |
| opt_b_i | input | 1 | 0 negated-size convention, 1 count-down convention |
| addr_i | input | 64 | Destination address operand |
| size_i | input | 64 | Size operand |
| data_i | input | 64 | Data operand; bits 7..0 are the fill byte |
| flags_i | input | 4 | Incoming flags |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| addr_o | output | 64 | Updated address |
| size_o | output | 64 | Updated size |
| flags_o | output | 4 | Flags result |
| fault_o | output | 1 | Last command faulted |
| fault_addr_o | output | 64 | Fault address |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 64 | Write address |
| mem_data_o | output | 8*BLK_BYTES | Write data (fill byte replicated) |
| mem_len_o | output | LEN_W | Write length in bytes |
| mem_ack_i | input | 1 | Write response |
| mem_cnt_i | input | LEN_W | Bytes actually written |
| tag_we_o | output | 1 | Tag store request |
| tag_addr_o | output | 64 | Granule address of the tag store |
| tag_o | output | 4 | Tag value |
| tag_ack_i | input | 1 | Tag store response |
| tag_err_i | input | 1 | Tag store failed |

## Verification
The assertions assume that the memory and tag responders answer only while the matching request is high. They also assume that a response never arrives in the same cycle as the request edge, and that `mem_cnt_i` never exceeds the requested length. The bench responds one half-cycle after it sees a request and drops the response on the next half-cycle. Its injected short writes always report 16 bytes fewer than requested. The random regions are granule-aligned, are at most 256 bytes long, and stay inside the modelled 4 KiB array.

// File: rtl/tag_fill_pkg.sv
`timescale 1ns/1ps
package tag_fill_pkg;
  localparam int unsigned GRANULE = 16;
  localparam int unsigned TAG_LSB = 56;

  typedef enum logic [1:0] {
    STG_PRO  = 2'd0,
    STG_MAIN = 2'd1,
    STG_EPI  = 2'd2
  } stage_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_MEM,
    S_TAG,
    S_FIN
  } fsm_e;
endpackage

// File: rtl/tf_precond.sv
`timescale 1ns/1ps
module tf_precond #(
  parameter logic [63:0] MAX_SIZE = 64'h0000_0000_0100_0000
) (
  input  logic [63:0] addr_i,
  input  logic [63:0] size_i,
  input  logic        opt_b_i,
  output logic [63:0] addr_o,
  output logic [63:0] size_o,
  output logic [3:0]  flags_o,
  output logic        fault_o
);
  logic [63:0] clamped;

  always_comb begin
    clamped = (size_i > MAX_SIZE) ? MAX_SIZE : size_i;
    fault_o = (clamped[3:0] != 4'd0) || ((clamped != 64'd0) && (addr_i[3:0] != 4'd0));
    if (opt_b_i) begin
      addr_o  = addr_i;
      size_o  = clamped;
      flags_o = 4'b0010;
    end else begin
      addr_o  = addr_i + clamped;
      size_o  = 64'd0 - clamped;
      flags_o = 4'b0000;
    end
  end
endmodule

// File: rtl/tf_stage_plan.sv
`timescale 1ns/1ps
module tf_stage_plan #(
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic [63:0] addr_i,
  input  logic [63:0] size_i,
  input  logic        opt_b_i,
  input  logic        last_i,
  output logic [63:0] stage_cnt_o,
  output logic        fault_o,
  output logic [63:0] fault_addr_o
);
  localparam logic [63:0] BLK_MASK = ~(64'(BLK_BYTES) - 64'd1);

  logic [63:0] remain;

  always_comb begin
    if (opt_b_i) remain = ($signed(size_i) > 0) ? size_i : 64'd0;
    else         remain = ($signed(size_i) < 0) ? (64'd0 - size_i) : 64'd0;
    stage_cnt_o  = last_i ? remain : (remain & BLK_MASK);
    fault_o      = (size_i[3:0] != 4'd0) || ((size_i != 64'd0) && (addr_i[3:0] != 4'd0));
    fault_addr_o = opt_b_i ? addr_i : (addr_i + size_i);
  end
endmodule

// File: rtl/tag_fill_engine.sv
`timescale 1ns/1ps
module tag_fill_engine
  import tag_fill_pkg::*;
#(
  parameter int unsigned BLK_BYTES = 16,
  parameter logic [63:0] MAX_SIZE  = 64'h0000_0000_0100_0000,
  parameter int unsigned LEN_W     = $clog2(BLK_BYTES) + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [1:0]             stage_i,
  input  logic                   opt_b_i,
  input  logic [63:0]            addr_i,
  input  logic [63:0]            size_i,
  input  logic [63:0]            data_i,
  input  logic [3:0]             flags_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [63:0]            addr_o,
  output logic [63:0]            size_o,
  output logic [3:0]             flags_o,
  output logic                   fault_o,
  output logic [63:0]            fault_addr_o,
  output logic                   mem_req_o,
  output logic [63:0]            mem_addr_o,
  output logic [8*BLK_BYTES-1:0] mem_data_o,
  output logic [LEN_W-1:0]       mem_len_o,
  input  logic                   mem_ack_i,
  input  logic [LEN_W-1:0]       mem_cnt_i,
  output logic                   tag_we_o,
  output logic [63:0]            tag_addr_o,
  output logic [3:0]             tag_o,
  input  logic                   tag_ack_i,
  input  logic                   tag_err_i
);
  localparam int unsigned GI_W = LEN_W - 4;

  fsm_e            state_q;
  logic [63:0]     cur_addr_q, cur_size_q, stg_cnt_q, fault_addr_q;
  logic [3:0]      flags_q;
  logic            fault_q, opt_b_q;
  logic [7:0]      fill_q;
  logic [GI_W-1:0] gidx_q;

  logic [63:0]     pre_addr, pre_size;
  logic [3:0]      pre_flags;
  logic            pre_fault;
  logic [63:0]     plan_cnt, plan_faddr;
  logic            plan_fault;
  logic [LEN_W-1:0] step_len;
  logic [63:0]     blk_addr;

  tf_precond #(.MAX_SIZE(MAX_SIZE)) u_pre (
    .addr_i (addr_i),
    .size_i (size_i),
    .opt_b_i(opt_b_i),
    .addr_o (pre_addr),
    .size_o (pre_size),
    .flags_o(pre_flags),
    .fault_o(pre_fault)
  );

  tf_stage_plan #(.BLK_BYTES(BLK_BYTES)) u_plan (
    .addr_i      (addr_i),
    .size_i      (size_i),
    .opt_b_i     (opt_b_i),
    .last_i      (stage_i == STG_EPI),
    .stage_cnt_o (plan_cnt),
    .fault_o     (plan_fault),
    .fault_addr_o(plan_faddr)
  );

  assign step_len = (stg_cnt_q >= 64'(BLK_BYTES)) ? LEN_W'(BLK_BYTES) : stg_cnt_q[LEN_W-1:0];
  assign blk_addr = opt_b_q ? cur_addr_q : (cur_addr_q + cur_size_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_IDLE;
      cur_addr_q   <= '0;
      cur_size_q   <= '0;
      stg_cnt_q    <= '0;
      fault_addr_q <= '0;
      flags_q      <= '0;
      fault_q      <= 1'b0;
      opt_b_q      <= 1'b0;
      fill_q       <= '0;
      gidx_q       <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i && (stage_i != 2'd3)) begin
          fault_q <= 1'b0;
          opt_b_q <= opt_b_i;
          fill_q  <= data_i[7:0];
          state_q <= S_FIN;
          if (stage_i == STG_PRO) begin
            if (pre_fault) begin
              cur_addr_q   <= addr_i;
              cur_size_q   <= size_i;
              flags_q      <= flags_i;
              fault_q      <= 1'b1;
              fault_addr_q <= addr_i;
            end else begin
              cur_addr_q <= pre_addr;
              cur_size_q <= pre_size;
              flags_q    <= pre_flags;
            end
          end else begin
            cur_addr_q <= addr_i;
            cur_size_q <= size_i;
            flags_q    <= flags_i;
            stg_cnt_q  <= plan_cnt;
            if (plan_fault) begin
              fault_q      <= 1'b1;
              fault_addr_q <= plan_faddr;
            end else if (plan_cnt != 64'd0) begin
              state_q <= S_MEM;
            end
          end
        end
        S_MEM: if (mem_ack_i) begin
          if (mem_cnt_i != step_len) begin
            fault_q      <= 1'b1;
            fault_addr_q <= blk_addr;
            state_q      <= S_FIN;
          end else begin
            gidx_q  <= step_len[LEN_W-1:4] - GI_W'(1);
            state_q <= S_TAG;
          end
        end
        S_TAG: if (tag_ack_i) begin
          if (tag_err_i) begin
            fault_q      <= 1'b1;
            fault_addr_q <= blk_addr;
            state_q      <= S_FIN;
          end else if (gidx_q == '0) begin
            if (opt_b_q) begin
              cur_addr_q <= cur_addr_q + 64'(step_len);
              cur_size_q <= cur_size_q - 64'(step_len);
            end else begin
              cur_size_q <= cur_size_q + 64'(step_len);
            end
            stg_cnt_q <= stg_cnt_q - 64'(step_len);
            state_q   <= (stg_cnt_q == 64'(step_len)) ? S_FIN : S_MEM;
          end else begin
            gidx_q <= gidx_q - GI_W'(1);
          end
        end
        S_FIN: state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FIN);
  assign addr_o       = cur_addr_q;
  assign size_o       = cur_size_q;
  assign flags_o      = flags_q;
  assign fault_o      = fault_q;
  assign fault_addr_o = fault_addr_q;
  assign mem_req_o    = (state_q == S_MEM);
  assign mem_addr_o   = blk_addr;
  assign mem_len_o    = step_len;
  assign mem_data_o   = {BLK_BYTES{fill_q}};
  assign tag_we_o     = (state_q == S_TAG);
  assign tag_addr_o   = blk_addr + 64'({gidx_q, 4'b0000});
  assign tag_o        = blk_addr[TAG_LSB+3:TAG_LSB];

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r13_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  a_r7_mem_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_len_o[3:0] == 4'd0 && mem_len_o != '0 && mem_len_o <= LEN_W'(BLK_BYTES)));
  a_r7_mem_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[3:0] == 4'd0));
  a_r9_tag_desc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_we_o && tag_ack_i && !tag_err_i && gidx_q != '0) |=>
      (tag_we_o && tag_addr_o == $past(tag_addr_o) - 64'd16 && tag_o == $past(tag_o)));
  a_r12_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(flags_o));
  a_r10_quiet_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_req_o && !tag_we_o));
endmodule

// File: tb/tag_fill_engine_tb.sv
`timescale 1ns/1ps
module tag_fill_engine_tb;
  localparam int unsigned BLK = 32;
  localparam int unsigned LW  = $clog2(BLK) + 1;
  localparam logic [63:0] MAXS = 64'd1024;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start = 0, opt_b = 0;
  logic [1:0] stage = 0;
  logic [63:0] addr = 0, size = 0, data = 0;
  logic [3:0] flags = 0;
  logic busy_o, done_o, fault_o, mem_req_o, tag_we_o;
  logic [63:0] addr_o, size_o, fault_addr_o, mem_addr_o, tag_addr_o;
  logic [3:0] flags_o, tag_o;
  logic [8*BLK-1:0] mem_data_o;
  logic [LW-1:0] mem_len_o;
  logic mem_ack = 0, tag_ack = 0, tag_err = 0;
  logic [LW-1:0] mem_cnt = '0;

  tag_fill_engine #(.BLK_BYTES(BLK), .MAX_SIZE(MAXS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stage_i(stage), .opt_b_i(opt_b),
    .addr_i(addr), .size_i(size), .data_i(data), .flags_i(flags),
    .busy_o(busy_o), .done_o(done_o), .addr_o(addr_o), .size_o(size_o), .flags_o(flags_o),
    .fault_o(fault_o), .fault_addr_o(fault_addr_o),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .mem_len_o(mem_len_o), .mem_ack_i(mem_ack), .mem_cnt_i(mem_cnt),
    .tag_we_o(tag_we_o), .tag_addr_o(tag_addr_o), .tag_o(tag_o),
    .tag_ack_i(tag_ack), .tag_err_i(tag_err));

  int tests = 0, fails = 0;
  logic [7:0] mem_m [0:4095];
  logic [7:0] exp_m [0:4095];
  logic [3:0] tag_m [0:255];
  logic [3:0] exp_t [0:255];
  logic [63:0] tlog [0:63];
  int n_mw = 0, n_tw = 0, short_at = -1, terr_at = -1;

  always @(negedge clk) begin
    if (mem_req_o && !mem_ack) begin
      mem_ack <= 1'b1;
      if (n_mw == short_at) mem_cnt <= mem_len_o - LW'(16);
      else begin
        mem_cnt <= mem_len_o;
        for (int i = 0; i < int'(mem_len_o); i++)
          mem_m[(mem_addr_o[11:0] + 12'(i))] = mem_data_o[8*i +: 8];
      end
      n_mw++;
    end else mem_ack <= 1'b0;
    if (tag_we_o && !tag_ack) begin
      tag_ack <= 1'b1;
      tag_err <= (n_tw == terr_at);
      if (n_tw != terr_at) tag_m[tag_addr_o[11:4]] = tag_o;
      if (n_tw < 64) tlog[n_tw] = tag_addr_o;
      n_tw++;
    end else begin
      tag_ack <= 1'b0;
      tag_err <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] st, input logic ob, input logic [63:0] a,
                         input logic [63:0] s, input logic [63:0] d, input logic [3:0] f);
    int lim;
    n_mw = 0; n_tw = 0;
    @(negedge clk);
    stage = st; opt_b = ob; addr = a; size = s; data = d; flags = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lim = 0;
    while (!done_o && lim < 3000) begin
      @(negedge clk);
      lim++;
    end
    if (!done_o) chk("R13 done timeout", 64'd0, 64'd1);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 4096; i++) if (mem_m[i] !== exp_m[i]) bad++;
    chk({req, " bytes"}, 64'(bad), 64'd0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (tag_m[i] !== exp_t[i]) bad++;
    chk({req, " tags"}, 64'(bad), 64'd0);
  endtask

  task automatic sync_model();
    for (int i = 0; i < 4096; i++) exp_m[i] = mem_m[i];
    for (int i = 0; i < 256; i++) exp_t[i] = tag_m[i];
  endtask

  task automatic do_fill(input logic ob, input logic [63:0] base, input logic [63:0] len,
                         input logic [3:0] tg, input logic [63:0] d);
    logic [63:0] a0, mcnt, pa, ps;
    logic [3:0] pf;
    bit ok;
    a0 = {4'd0, tg, 56'd0} | base;
    mcnt = len & ~64'(BLK - 1);
    run_cmd(2'd0, ob, a0, len, d, 4'hF);
    chk("R3/R4 pro fault", 64'(fault_o), 64'd0);
    if (ob) begin
      chk("R4 pro addr", addr_o, a0); chk("R4 pro size", size_o, len);
      chk("R4 pro flags", 64'(flags_o), 64'h2);
    end else begin
      chk("R3 pro addr", addr_o, a0 + len); chk("R3 pro size", size_o, 64'd0 - len);
      chk("R3 pro flags", 64'(flags_o), 64'h0);
    end
    pa = addr_o; ps = size_o; pf = flags_o;
    run_cmd(2'd1, ob, pa, ps, d, pf);
    chk("R7 main writes", 64'(n_mw), mcnt / BLK);
    chk("R12 main flags", 64'(flags_o), 64'(pf));
    if (ob) begin
      chk("R6 main addr", addr_o, a0 + mcnt); chk("R6 main size", size_o, len - mcnt);
    end else begin
      chk("R5 main addr", addr_o, a0 + len); chk("R5 main size", size_o, mcnt - len);
    end
    ok = 1;
    for (int k = 0; k + 1 < n_tw && k + 1 < 64; k += 2)
      if (tlog[k] != tlog[k + 1] + 64'd16) ok = 0;
    chk("R9 tag order", 64'(ok), 64'd1);
    run_cmd(2'd2, ob, addr_o, size_o, d, flags_o);
    chk("R7 epi writes", 64'(n_mw), ((len - mcnt) != 0) ? 64'd1 : 64'd0);
    chk(ob ? "R6 epi addr" : "R5 epi addr", addr_o, a0 + len);
    chk(ob ? "R6 epi size" : "R5 epi size", size_o, 64'd0);
    for (int i = 0; i < int'(len); i++) exp_m[(base[11:0] + 12'(i))] = d[7:0];
    for (int i = 0; i < int'(len); i += 16) exp_t[base[11:4] + 8'(i / 16)] = tg;
    cmp_mem(ob ? "R1/R9 opt B" : "R1/R9 opt A");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] b, l;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) begin mem_m[i] = 8'hEE; exp_m[i] = 8'hEE; end
    for (int i = 0; i < 256; i++) begin tag_m[i] = 4'h0; exp_t[i] = 4'h0; end
    repeat (3) @(negedge clk);
    chk("R13 reset busy", 64'(busy_o), 0); chk("R13 reset done", 64'(done_o), 0);
    chk("R12 reset flags", 64'(flags_o), 0);
    chk("R7 reset req", 64'({mem_req_o, tag_we_o}), 0);
    rst_n = 1'b1;

    do_fill(1'b0, 64'h100, 64'd80, 4'hA, 64'h1234_5678_9ABC_DE5A);
    do_fill(1'b1, 64'h300, 64'd96, 4'h3, 64'hFFFF_0000_0000_00C3);
    do_fill(1'b1, 64'h500, 64'd0, 4'h7, 64'h11);
    for (int it = 0; it < 20; it++) begin
      b = 64'(($urandom % 128) * 16);
      l = 64'(($urandom % 17) * 16);
      do_fill(1'($urandom), b, l, 4'($urandom), {$urandom, $urandom});
    end

    // R2 prologue faults
    run_cmd(2'd0, 1'b0, 64'h108, 64'd32, 0, 4'h5);
    chk("R2 misaligned addr fault", 64'(fault_o), 1);
    chk("R2 fault addr", fault_addr_o, 64'h108);
    chk("R2 size kept", size_o, 64'd32); chk("R2 flags kept", 64'(flags_o), 64'h5);
    run_cmd(2'd0, 1'b1, 64'h100, 64'd40, 0, 4'h0);
    chk("R2 misaligned size fault", 64'(fault_o), 1);
    run_cmd(2'd0, 1'b1, 64'h107, 64'd0, 0, 4'h0);
    chk("R2 zero size no fault", 64'(fault_o), 0);
    chk("R4 zero size flags", 64'(flags_o), 64'h2);
    run_cmd(2'd0, 1'b0, 64'h0, 64'h10000, 0, 4'h0);
    chk("R2 clamp addr", addr_o, MAXS); chk("R2 clamp size", size_o, 64'd0 - MAXS);
    run_cmd(2'd0, 1'b1, 64'h0, 64'h10000, 0, 4'h0);
    chk("R2 clamp size B", size_o, MAXS);

    // R8 main/epilogue alignment faults
    run_cmd(2'd1, 1'b0, 64'h200, 64'd0 - 64'd40, 0, 4'h0);
    chk("R8 A fault", 64'(fault_o), 1);
    chk("R8 A fault addr", fault_addr_o, 64'h200 - 64'd40);
    chk("R8 A no write", 64'(n_mw), 0);
    run_cmd(2'd2, 1'b1, 64'h205, 64'd32, 0, 4'h0);
    chk("R8 B fault addr", fault_addr_o, 64'h205);
    chk("R8 B no write", 64'(n_mw), 0);

    // R10 short write
    short_at = 1;
    run_cmd(2'd1, 1'b1, 64'h400, 64'd96, 64'h77, 4'h2);
    short_at = -1;
    chk("R10 fault", 64'(fault_o), 1);
    chk("R10 addr progress", addr_o, 64'h420); chk("R10 size progress", size_o, 64'd64);
    chk("R10 fault addr", fault_addr_o, 64'h420);
    chk("R10 stop", 64'(n_mw), 2);

    // R11 tag error
    terr_at = 1;
    run_cmd(2'd1, 1'b0, 64'h640, 64'd0 - 64'd64, 64'h33, 4'h0);
    terr_at = -1;
    chk("R11 fault", 64'(fault_o), 1);
    chk("R11 size kept", size_o, 64'd0 - 64'd64); chk("R11 addr kept", addr_o, 64'h640);
    chk("R11 fault addr", fault_addr_o, 64'h600);
    chk("R11 stop", 64'(n_mw), 1);
    sync_model();

    // R7 epilogue on an uneven remainder; R12 odd flags pass through
    run_cmd(2'd2, 1'b1, 64'h800, 64'd48, 64'h5C, 4'b1001);
    chk("R7 epi two writes", 64'(n_mw), 2);
    chk("R6 epi final addr", addr_o, 64'h830);
    chk("R12 epi flags", 64'(flags_o), 64'b1001);
    for (int i = 0; i < 48; i++) exp_m[12'h800 + 12'(i)] = 8'h5C;
    for (int i = 0; i < 3; i++) exp_t[8'h80 + 8'(i)] = 4'h0;
    cmp_mem("R1 epi");
    @(negedge clk);
    chk("R13 done one cycle", 64'(done_o), 0);

    // R13 stage code 3 ignored
    @(negedge clk);
    stage = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R13 code 3 busy", 64'(busy_o), 0);
    @(negedge clk);
    chk("R13 code 3 done", 64'(done_o), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule